// File: doc/BRIEF.md
# Synchronous Byte-Lane Cache SRAM

This block is a single-ported synchronous memory for a processor cache. It has one bidirectional data bus shared by reads and writes. Every control, address and data input is sampled on the rising clock edge. The stored word has two 9-bit lanes: the upper lane holds bits 17:9 and the lower lane holds bits 8:0. Each lane has its own write strobe. Bit 17 and bit 8 are usually parity, but the memory stores and returns them like any other bit and never checks them. A separate burst address generator supplies the address on every cycle, so this block sees only plain word addresses.

A cycle with the select input high and both lane strobes low is a read. The addressed word is captured into an output register and appears on the bus in the next cycle. A cycle with select high and at least one strobe high is a write. The array is updated at that edge with no external write pulse. The output enable acts without the clock: it gates the bus drivers combinationally. The block releases the bus whenever no read result is pending, whenever output enable is low, and whenever a lane strobe is high.

The bus has no valid/ready handshake and there is no back-pressure. The block accepts an access on every clock edge, and a read result is valid only in the single cycle after its read.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, while no read has been performed, the bus `dq` is high impedance even with `oe` high.
- R2: A read is `sel`=1 with `we_hi`=`we_lo`=0 at edge N. From edge N until edge N+1, `dq` carries the word stored at `addr`, provided `oe` is high and neither strobe is high.
- R3: A write with only `we_hi`=1 replaces bits 17:9 of the addressed word with `dq[17:9]`. Bits 8:0 are left unchanged.
- R4: A write with only `we_lo`=1 replaces bits 8:0 with `dq[8:0]`. Bits 17:9 are left unchanged.
- R5: A write with both strobes high replaces all 18 bits.
- R6: Bits 17 and 8 (the parity positions) are stored and returned unchanged, with no checking.
- R7: An edge with `sel`=0 neither writes the array nor starts a read. In the following cycle `dq` is high impedance.
- R8: With `oe` low, `dq` is high impedance. Raising `oe` again without a clock edge restores the pending read word on the bus.
- R9: The block does not drive `dq` while either lane strobe is high.
- R10: A read in the cycle right after a write to the same address returns the newly written data.
- R11: Back-to-back reads of different addresses each present their own word one cycle after their edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the read path |
| sel | input | 1 | Synchronous access select, sampled each edge |
| addr | input | ADDR_W | Word address from the burst generator |
| we_hi | input | 1 | Upper lane (bits 17:9) write strobe |
| we_lo | input | 1 | Lower lane (bits 8:0) write strobe |
| oe | input | 1 | Asynchronous bus output enable |
| dq | inout | 18 | Shared data bus |

## Verification
A write takes effect at its own edge, so the earliest read of that word can follow in the next cycle. A read result is due on `dq` in the cycle after its edge. Output enable and the lane strobes act on the bus at once, without waiting for a clock. The bench applies each cycle's inputs after the falling edge and checks `dq` 1 ns later, before the next rising edge. Its reference memory is updated at that rising edge, so each comparison sees exactly one register stage of delay for read data and zero stages for the enable gating. For output enable, the bench also toggles `oe` within a cycle and re-checks the bus, with no clock edge in between.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned LANES  = 2;
  localparam int unsigned WORD_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // self-timed write: array updated at the sampling edge
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= din;
  end

  // registered read data for this lane
  always_ff @(posedge clk) begin
    if (!rst_n)     dout <= '0;
    else if (rd_en) dout <= mem[addr];
  end
endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_pkg::*;
#(
  parameter int unsigned NLANE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic [NLANE-1:0] lane_we,
  output logic [NLANE-1:0] lane_wr,
  output logic             rd_en,
  output logic             rd_vld
);
  acc_e acc;

  always_comb begin
    if (!sel)          acc = ACC_IDLE;
    else if (|lane_we) acc = ACC_WRITE;
    else               acc = ACC_READ;
  end

  assign rd_en = (acc == ACC_READ);

  for (genvar g = 0; g < NLANE; g++) begin : g_wr
    assign lane_wr[g] = (acc == ACC_WRITE) && lane_we[g];
  end

  // registered select: a result is pending only after a read edge
  always_ff @(posedge clk) begin
    if (!rst_n) rd_vld <= 1'b0;
    else        rd_vld <= rd_en;
  end
endmodule

// File: rtl/sram_bus_gate.sv
module sram_bus_gate (
  input  logic oe,
  input  logic rd_vld,
  input  logic any_we,
  output logic bus_en
);
  // purely combinational: output enable needs no clock
  assign bus_en = oe && rd_vld && !any_we;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we_hi,
  input  logic              we_lo,
  input  logic              oe,
  inout  wire  [WORD_W-1:0] dq
);
  logic [LANES-1:0]  lane_we;
  logic [LANES-1:0]  lane_wr;
  logic              rd_en;
  logic              rd_vld;
  logic              bus_en;
  logic [WORD_W-1:0] rd_word;

  assign lane_we = {we_hi, we_lo};

  sram_access_ctrl #(.NLANE(LANES)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel),
    .lane_we(lane_we),
    .lane_wr(lane_wr),
    .rd_en  (rd_en),
    .rd_vld (rd_vld)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(lane_wr[l]),
      .rd_en(rd_en),
      .addr (addr),
      .din  (dq[l*LANE_W +: LANE_W]),
      .dout (rd_word[l*LANE_W +: LANE_W])
    );
  end

  sram_bus_gate u_gate (
    .oe    (oe),
    .rd_vld(rd_vld),
    .any_we(|lane_we),
    .bus_en(bus_en)
  );

  assign dq = bus_en ? rd_word : {WORD_W{1'bz}};
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic we_hi,
  input logic we_lo,
  input logic oe,
  input logic bus_en
);
  AST_RESET_RELEASE_HIZ: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> !bus_en); // R1
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && $past(sel && !we_hi && !we_lo) && oe && !we_hi && !we_lo) |-> bus_en); // R2
  AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && !$past(sel)) |-> !bus_en); // R7
  AST_OE_LOW_HIZ: assert property (@(posedge clk) disable iff (!rst_n) !oe |-> !bus_en); // R8
  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n) (we_hi || we_lo) |-> !bus_en); // R9
endmodule

bind sync_burst_sram sync_burst_sram_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .sel   (sel),
  .we_hi (we_hi),
  .we_lo (we_lo),
  .oe    (oe),
  .bus_en(bus_en)
);

// File: tb/sync_burst_sram_test.sv
`timescale 1ns/1ps
module sync_burst_sram_test;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel, we_hi, we_lo, oe;
  logic [AW-1:0] addr;
  logic [17:0]   tb_dat;
  wire  [17:0]   dq;
  wire           tb_en = we_hi | we_lo;

  assign dq = tb_en ? tb_dat : 18'bz;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [17:0] model [int];
  logic        m_vld;
  logic [17:0] m_dat;

  always #2 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr),
    .we_hi(we_hi), .we_lo(we_lo), .oe(oe), .dq(dq)
  );

  function automatic logic [17:0] expect_bus();
    if (tb_en)                  return tb_dat;
    else if (m_vld && oe)       return m_dat;
    else                        return 18'bz;
  endfunction

  task automatic check(string tag);
    logic [17:0] e;
    e = expect_bus();
    n_chk++;
    if (dq !== e) begin
      n_fail++;
      $display("FAIL %s: dq actual=%h expected=%h", tag, dq, e);
    end
  endtask

  // apply one cycle of inputs, check bus, then advance through the edge
  task automatic cyc(input logic s, input logic wh, input logic wl, input logic o,
                     input logic [AW-1:0] a, input logic [17:0] d, input string tag);
    sel = s; we_hi = wh; we_lo = wl; oe = o; addr = a; tb_dat = d;
    #1;
    check(tag);
    @(posedge clk);
    if (s && (wh || wl)) begin
      logic [17:0] w;
      w = model.exists(int'(a)) ? model[int'(a)] : 18'hx;
      if (wh) w[17:9] = d[17:9];
      if (wl) w[8:0]  = d[8:0];
      model[int'(a)] = w;
    end
    m_vld = s && !wh && !wl;
    if (m_vld) m_dat = model[int'(a)];
    @(negedge clk);
  endtask

  task automatic oe_flip(input logic o, input string tag);
    oe = o;
    #1;
    check(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel = 0; we_hi = 0; we_lo = 0; oe = 1; addr = '0; tb_dat = '0;
    m_vld = 0; m_dat = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    cyc(0, 0, 0, 1, 8'd0, 18'h0, "R1");
    cyc(0, 0, 0, 1, 8'd0, 18'h0, "R1");
    // full-word writes, parity positions set at address 9
    cyc(1, 1, 1, 1, 8'd5, 18'h2A5C3, "R9 R5");
    cyc(1, 1, 1, 1, 8'd6, 18'h3FFFF, "R9 R5");
    cyc(1, 1, 1, 1, 8'd7, 18'h00000, "R9 R5");
    cyc(1, 1, 1, 1, 8'd9, 18'h20100, "R9 R6");
    // back-to-back reads
    cyc(1, 0, 0, 1, 8'd5, 18'h0, "R9");
    cyc(1, 0, 0, 1, 8'd6, 18'h0, "R2 R5");
    cyc(1, 0, 0, 1, 8'd7, 18'h0, "R11");
    cyc(1, 0, 0, 1, 8'd9, 18'h0, "R11");
    cyc(0, 0, 0, 1, 8'd0, 18'h0, "R6");
    // single-lane writes
    cyc(1, 1, 0, 1, 8'd5, 18'h15555, "R9 R3");
    cyc(1, 0, 1, 1, 8'd6, 18'h00000, "R9 R4");
    cyc(1, 0, 1, 1, 8'd9, 18'h3FEFF, "R9 R6");
    cyc(1, 0, 0, 1, 8'd5, 18'h0, "R9");
    cyc(1, 0, 0, 1, 8'd6, 18'h0, "R3");
    cyc(1, 0, 0, 1, 8'd9, 18'h0, "R4");
    cyc(0, 0, 0, 1, 8'd0, 18'h0, "R6");
    // read right after write to the same address
    cyc(1, 1, 1, 1, 8'd7, 18'h12345, "R9");
    cyc(1, 0, 0, 1, 8'd7, 18'h0, "R9");
    cyc(0, 0, 0, 1, 8'd0, 18'h0, "R10");
    // deselected write ignored, deselected cycle gives no output
    cyc(0, 1, 1, 1, 8'd7, 18'h3FFFF, "R7 R9");
    cyc(1, 0, 0, 1, 8'd7, 18'h0, "R7");
    cyc(0, 0, 0, 1, 8'd0, 18'h0, "R7");
    cyc(0, 0, 0, 1, 8'd0, 18'h0, "R7");
    // asynchronous output enable
    cyc(1, 0, 0, 1, 8'd6, 18'h0, "R7");
    cyc(0, 0, 0, 0, 8'd0, 18'h0, "R8");
    oe_flip(1'b1, "R8");
    oe_flip(1'b0, "R8");
    oe_flip(1'b1, "R8");
    // write strobe right after a read releases the bus
    cyc(1, 0, 0, 1, 8'd5, 18'h0, "R8");
    cyc(1, 1, 0, 1, 8'd40, 18'h2AAAA, "R9");
    cyc(0, 0, 0, 1, 8'd0, 18'h0, "R7");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule